// File: doc/BRIEF.md
# Erased-Page Override Filter for ECC Page Reads

This block sits beside a flash page-read path and watches every 32-bit word of a page as it streams past: first a run of correction regions, then the spare area. It counts the zero bits in each region and in the spare area. When the read finishes, it merges these counts with the status word that the ECC decoder produced for the same page. A blank page has no valid parity, so the decoder reports an uncorrectable error for it. The filter turns that error into a pass only when every region and the spare area hold no more zero bits than a tolerance. The flips it then reports are the zeros it counted.

The stream is framed by a one-cycle `page_start` pulse. The filter knows the page geometry from its parameters, so it needs no end marker. The result appears on the cycle after the last spare word is accepted, as a one-cycle `res_valid` pulse. Two statistics run across pages: a running sum of corrected bits and a saturating count of pages that failed.

The controller has four states. `ST_IDLE` waits for `page_start`. `ST_DATA` takes region words and moves to `ST_SPARE` when the last word of the last region is accepted. `ST_SPARE` moves to `ST_RESULT` when the last spare word is accepted. `ST_RESULT` lasts one cycle and returns to `ST_IDLE`. A `page_start` pulse in any state sends the controller to `ST_DATA` and restarts the page.

Top module: `erased_page_filter`

## Requirements
- R1: After reset, `res_valid`, `page_ok` and `erased` are 0, and `fail_count` and `corrected_total` are 0.
- R2: `res_valid` is high for exactly one cycle. That cycle comes right after the clock edge that accepts word number REGIONS*REGION_WORDS+SPARE_WORDS-1 of the page, counting from 0. It is never high at any other time. Outside that cycle `page_ok`, `erased`, `max_flips` and `total_flips` are 0.
- R3: When the decoder fail flag (status bit 1) is 0, the page passes with `erased`=0, whatever the data holds. `total_flips` equals status bits 23:16. `max_flips` equals the largest `dec_region_cnt` given with `dec_region_vld` during the page.
- R4: When the fail flag is 1 and neither any region nor the spare area holds more than THRESH zero bits, the page passes with `erased`=1. `total_flips` is then the zero count over all data and spare words. `max_flips` is the largest zero count among the regions and the spare area.
- R5: When the fail flag is 1 and any single data region holds more than THRESH zero bits, `page_ok`=0, `erased`=0 and both flip outputs are 0.
- R6: With the fail flag set, a spare area holding more than THRESH zero bits fails the page even when every data region is all ones.
- R7: The limit applies to each region on its own. A region with exactly THRESH zeros passes, and a page whose regions each stay within THRESH passes even when its total is larger than THRESH.
- R8: `page_start` clears all per-page counts. Words accepted before a restart have no effect on the next result.
- R9: Words offered with `in_valid` while no page is open are not counted and produce no result.
- R10: On each passing page, `corrected_total` adds `total_flips`, and it holds at its maximum once that is reached.
- R11: On each failing page, `fail_count` increments, and it holds at 2^FAIL_W-1 once that is reached.
- R12: Cycles with `in_valid` low inside a page are not counted, and they move the result later by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | One-cycle pulse that opens or restarts a page |
| in_valid | input | 1 | `in_word` carries a page word this cycle |
| in_word | input | 32 | Page word: regions first, then the spare area |
| dec_region_vld | input | 1 | Decoder per-region corrected count is valid |
| dec_region_cnt | input | 8 | Decoder corrected bits for one region |
| dec_status | input | 32 | Decoder status: bit 1 uncorrectable, bits 23:16 page corrected total; sampled with the last spare word |
| res_valid | output | 1 | One-cycle result strobe |
| page_ok | output | 1 | Page passes (decoded or erased) |
| erased | output | 1 | Pass was granted by the erased override |
| max_flips | output | 15 | Largest per-region flip count |
| total_flips | output | 15 | Flips over the whole page |
| fail_count | output | 8 | Saturating count of failing pages |
| corrected_total | output | 32 | Saturating running sum of corrected bits |

## Verification
A word counter that drifts by one moves the region boundary. The page then ends one word early or late, so `res_valid` shows up a cycle off, or a zero bit is credited to a neighbouring region. A boundary pattern of exactly THRESH zeros placed on the last word of a region turns that into a wrong pass or fail on the same page. A region accumulator left uncleared shows up on the next page's `total_flips`. A latched status taken on the wrong cycle shows up at once as a swapped `erased` or `page_ok` in the result cycle. A saturation error shows up only after enough pages, so the statistics are driven up to their limits and read in the cycle after each result.

// File: rtl/efp_pkg.sv
package efp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_SPARE  = 2'd2,
        ST_RESULT = 2'd3
    } efp_state_e;

    localparam int WORD_W   = 32;
    localparam int FAIL_BIT = 1;
    localparam int CNT_LSB  = 16;
    localparam int CNT_W    = 8;
endpackage

// File: rtl/efp_zero_count.sv
module efp_zero_count #(
    parameter int W = 32,
    localparam int ZW = $clog2(W + 1)
) (
    input  logic [W-1:0]  word,
    output logic [ZW-1:0] zeros
);
    always_comb begin
        zeros = '0;
        for (int b = 0; b < W; b++) begin
            zeros = zeros + ZW'(~word[b]);
        end
    end
endmodule

// File: rtl/efp_ctrl.sv
module efp_ctrl
    import efp_pkg::*;
#(
    parameter int REGION_WORDS = 128,
    parameter int REGIONS      = 4,
    parameter int SPARE_WORDS  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       page_start,
    input  logic       in_valid,
    output efp_state_e state,
    output logic       take,
    output logic       region_end,
    output logic       page_end
);
    localparam int WMAX = (REGION_WORDS > SPARE_WORDS) ? REGION_WORDS : SPARE_WORDS;
    localparam int WC_W = (WMAX > 1) ? $clog2(WMAX) : 1;
    localparam int RG_W = (REGIONS > 1) ? $clog2(REGIONS) : 1;
    localparam logic [WC_W-1:0] REG_LAST = WC_W'(REGION_WORDS - 1);
    localparam logic [WC_W-1:0] SPR_LAST = WC_W'(SPARE_WORDS - 1);
    localparam logic [RG_W-1:0] RGN_LAST = RG_W'(REGIONS - 1);

    efp_state_e      state_q, state_d;
    logic [WC_W-1:0] wcnt_q;
    logic [RG_W-1:0] rcnt_q;
    logic            in_page;

    assign state   = state_q;
    assign in_page = (state_q == ST_DATA) || (state_q == ST_SPARE);

    always_comb begin
        take       = in_page && in_valid && !page_start;
        region_end = take && (((state_q == ST_DATA)  && (wcnt_q == REG_LAST)) ||
                              ((state_q == ST_SPARE) && (wcnt_q == SPR_LAST)));
        page_end   = region_end && (state_q == ST_SPARE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (page_start) state_d = ST_DATA;
            ST_DATA: begin
                if (page_start)
                    state_d = ST_DATA;
                else if (region_end && (rcnt_q == RGN_LAST))
                    state_d = ST_SPARE;
            end
            ST_SPARE: begin
                if (page_start)    state_d = ST_DATA;
                else if (page_end) state_d = ST_RESULT;
            end
            ST_RESULT: state_d = page_start ? ST_DATA : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else if (page_start) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else if (take) begin
            if (region_end) begin
                wcnt_q <= '0;
                rcnt_q <= (state_q == ST_DATA && rcnt_q != RGN_LAST) ? rcnt_q + 1'b1 : '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    assert_word_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (wcnt_q <= REG_LAST));
    assert_spare_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPARE) |-> (wcnt_q <= SPR_LAST));
    assert_result_from_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESULT) |-> ($past(state_q) == ST_SPARE));
    assert_result_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESULT) |=> (state_q != ST_RESULT));
endmodule

// File: rtl/efp_region_acc.sv
module efp_region_acc #(
    parameter int CW     = 15,
    parameter int ZW     = 6,
    parameter int THRESH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic          region_end,
    input  logic [ZW-1:0] zeros,
    input  logic          dec_take,
    input  logic [7:0]    dec_cnt,
    output logic [CW-1:0] tot_zeros,
    output logic [CW-1:0] max_zeros,
    output logic          over,
    output logic [7:0]    dec_max
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cur_q;
    logic [CW-1:0] cur_sum;

    assign cur_sum = cur_q + CW'(zeros);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            tot_zeros <= '0;
            max_zeros <= '0;
            over      <= 1'b0;
        end else if (clear) begin
            cur_q     <= '0;
            tot_zeros <= '0;
            max_zeros <= '0;
            over      <= 1'b0;
        end else if (take) begin
            tot_zeros <= tot_zeros + CW'(zeros);
            if (region_end) begin
                cur_q <= '0;
                if (cur_sum > max_zeros) max_zeros <= cur_sum;
                if (cur_sum > LIMIT)     over      <= 1'b1;
            end else begin
                cur_q <= cur_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           dec_max <= '0;
        else if (clear)                       dec_max <= '0;
        else if (dec_take && dec_cnt > dec_max) dec_max <= dec_cnt;
    end

    assert_total_covers_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tot_zeros >= max_zeros);
    assert_over_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(over) && !$past(clear)) |-> over);
endmodule

// File: rtl/efp_stats.sv
module efp_stats #(
    parameter int CW     = 15,
    parameter int FAIL_W = 8,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              ok,
    input  logic [CW-1:0]     flips,
    output logic [FAIL_W-1:0] fail_count,
    output logic [STAT_W-1:0] corrected_total
);
    localparam int SW = ((STAT_W > CW) ? STAT_W : CW) + 1;
    localparam logic [SW-1:0] STAT_MAX = SW'({STAT_W{1'b1}});

    logic [SW-1:0] sum;
    assign sum = SW'(corrected_total) + SW'(flips);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_count      <= '0;
            corrected_total <= '0;
        end else if (upd) begin
            if (ok)
                corrected_total <= (sum > STAT_MAX) ? {STAT_W{1'b1}} : sum[STAT_W-1:0];
            else if (fail_count != {FAIL_W{1'b1}})
                fail_count <= fail_count + 1'b1;
        end
    end

    assert_fail_monotone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail_count >= $past(fail_count));
    assert_stat_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        corrected_total >= $past(corrected_total));
endmodule

// File: rtl/erased_page_filter.sv
module erased_page_filter
    import efp_pkg::*;
#(
    parameter int REGION_WORDS = 128,
    parameter int REGIONS      = 4,
    parameter int SPARE_WORDS  = 16,
    parameter int ECC_STRENGTH = 8,
    parameter int THRESH       = ECC_STRENGTH / 2,
    parameter int FAIL_W       = 8,
    parameter int STAT_W       = 32,
    localparam int TOTAL_WORDS = REGIONS * REGION_WORDS + SPARE_WORDS,
    localparam int CW_RAW      = $clog2(WORD_W * TOTAL_WORDS + 1),
    localparam int CW          = (CW_RAW > CNT_W) ? CW_RAW : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic              dec_region_vld,
    input  logic [7:0]        dec_region_cnt,
    input  logic [31:0]       dec_status,
    output logic              res_valid,
    output logic              page_ok,
    output logic              erased,
    output logic [CW-1:0]     max_flips,
    output logic [CW-1:0]     total_flips,
    output logic [FAIL_W-1:0] fail_count,
    output logic [STAT_W-1:0] corrected_total
);
    localparam int ZW = $clog2(WORD_W + 1);

    efp_state_e    state;
    logic          take, region_end, page_end, dec_take;
    logic [ZW-1:0] zeros;
    logic [CW-1:0] tot_zeros, max_zeros;
    logic          over;
    logic [7:0]    dec_max;
    logic          fail_q;
    logic [7:0]    cnt_q;
    logic          unused_status_bits;

    assign unused_status_bits = ^{dec_status[31:CNT_LSB+CNT_W], dec_status[CNT_LSB-1:FAIL_BIT+1], dec_status[0]};
    assign dec_take = dec_region_vld && !page_start &&
                      ((state == ST_DATA) || (state == ST_SPARE));

    efp_ctrl #(
        .REGION_WORDS(REGION_WORDS), .REGIONS(REGIONS), .SPARE_WORDS(SPARE_WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .in_valid(in_valid),
        .state(state), .take(take), .region_end(region_end), .page_end(page_end)
    );

    efp_zero_count #(.W(WORD_W)) u_zc (.word(in_word), .zeros(zeros));

    efp_region_acc #(.CW(CW), .ZW(ZW), .THRESH(THRESH)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(page_start), .take(take),
        .region_end(region_end), .zeros(zeros), .dec_take(dec_take),
        .dec_cnt(dec_region_cnt), .tot_zeros(tot_zeros), .max_zeros(max_zeros),
        .over(over), .dec_max(dec_max)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            cnt_q  <= '0;
        end else if (page_end) begin
            fail_q <= dec_status[FAIL_BIT];
            cnt_q  <= dec_status[CNT_LSB +: CNT_W];
        end
    end

    always_comb begin
        res_valid   = (state == ST_RESULT);
        page_ok     = 1'b0;
        erased      = 1'b0;
        max_flips   = '0;
        total_flips = '0;
        if (res_valid) begin
            if (!fail_q) begin
                page_ok     = 1'b1;
                total_flips = CW'(cnt_q);
                max_flips   = CW'(dec_max);
            end else if (!over) begin
                page_ok     = 1'b1;
                erased      = 1'b1;
                total_flips = tot_zeros;
                max_flips   = max_zeros;
            end
        end
    end

    efp_stats #(.CW(CW), .FAIL_W(FAIL_W), .STAT_W(STAT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .upd(res_valid), .ok(page_ok), .flips(total_flips),
        .fail_count(fail_count), .corrected_total(corrected_total)
    );

    assert_erased_implies_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> page_ok);
    assert_result_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));
    assert_quiet_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!page_ok && !erased && total_flips == '0 && max_flips == '0));
    assert_total_covers_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && erased) |-> (total_flips >= max_flips));
endmodule

// File: tb/sim_erased_page_filter.sv
module sim_erased_page_filter;
    localparam int PERIOD = 10;
    localparam int RW = 8;
    localparam int NR = 4;
    localparam int NS = 4;
    localparam int TH = 4;
    localparam int FW = 3;
    localparam int SW = 10;
    localparam int DW = NR * RW;
    localparam int NW = DW + NS;
    localparam int CW_RAW = $clog2(32 * NW + 1);
    localparam int CW = (CW_RAW > 8) ? CW_RAW : 8;
    localparam longint FAIL_MAX = (1 << FW) - 1;
    localparam longint STAT_MAX = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic page_start = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic dec_region_vld = 1'b0;
    logic [7:0] dec_region_cnt = '0;
    logic [31:0] dec_status = '0;
    logic res_valid, page_ok, erased;
    logic [CW-1:0] max_flips, total_flips;
    logic [FW-1:0] fail_count;
    logic [SW-1:0] corrected_total;

    erased_page_filter #(
        .REGION_WORDS(RW), .REGIONS(NR), .SPARE_WORDS(NS), .ECC_STRENGTH(8),
        .THRESH(TH), .FAIL_W(FW), .STAT_W(SW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .in_valid(in_valid),
        .in_word(in_word), .dec_region_vld(dec_region_vld), .dec_region_cnt(dec_region_cnt),
        .dec_status(dec_status), .res_valid(res_valid), .page_ok(page_ok), .erased(erased),
        .max_flips(max_flips), .total_flips(total_flips), .fail_count(fail_count),
        .corrected_total(corrected_total)
    );

    always #(PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    logic [31:0] pw [NW];
    int rc [NR];
    longint exp_fail = 0;
    longint exp_corr = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_blank();
        for (int i = 0; i < NW; i++) pw[i] = 32'hFFFF_FFFF;
        for (int r = 0; r < NR; r++) rc[r] = 0;
    endtask

    task automatic zap(input int w, input int n);
        for (int b = 0; b < n; b++) pw[w][b] = 1'b0;
    endtask

    task automatic run_page(input string tag, input logic fail, input int cnt, input logic gap);
        int zr, maxz, totz, maxrc, early;
        logic ovr, eok, eer;
        longint etot, emax;
        maxz = 0; totz = 0; maxrc = 0; ovr = 1'b0; early = 0;
        for (int r = 0; r <= NR; r++) begin
            zr = 0;
            for (int w = 0; w < ((r < NR) ? RW : NS); w++)
                zr += 32 - $countones(pw[r * RW + w]);
            totz += zr;
            if (zr > maxz) maxz = zr;
            if (zr > TH) ovr = 1'b1;
            if (r < NR && rc[r] > maxrc) maxrc = rc[r];
        end
        if (!fail)     begin eok = 1; eer = 0; etot = cnt;  emax = maxrc; end
        else if (!ovr) begin eok = 1; eer = 1; etot = totz; emax = maxz;  end
        else           begin eok = 0; eer = 0; etot = 0;    emax = 0;     end

        dec_status = 32'h8000_0001;
        dec_status[1] = fail;
        dec_status[23:16] = 8'(cnt);
        @(negedge clk); page_start = 1'b1;
        @(negedge clk); page_start = 1'b0;
        for (int i = 0; i < NW; i++) begin
            if (gap && (i % 3 == 1)) begin
                in_valid = 1'b0; in_word = 32'h0; dec_region_vld = 1'b0;
                @(negedge clk);
                if (res_valid) early++;
            end
            in_word = pw[i];
            in_valid = 1'b1;
            dec_region_vld = (i < DW) && (i % RW == RW - 1);
            dec_region_cnt = (i < DW) ? 8'(rc[i / RW]) : 8'd0;
            @(negedge clk);
            if (res_valid && i != NW - 1) early++;
        end
        in_valid = 1'b0; dec_region_vld = 1'b0; in_word = 32'h0;
        chk({tag, " R2 res_valid in result cycle"}, res_valid, 1);
        chk({tag, " R2 no early result"}, early, 0);
        chk({tag, " page_ok"}, page_ok, eok);
        chk({tag, " erased"}, erased, eer);
        chk({tag, " total_flips"}, total_flips, etot);
        chk({tag, " max_flips"}, max_flips, emax);
        if (eok) exp_corr = (exp_corr + etot > STAT_MAX) ? STAT_MAX : exp_corr + etot;
        else if (exp_fail < FAIL_MAX) exp_fail++;
        @(negedge clk);
        chk({tag, " R2 res_valid one cycle"}, res_valid, 0);
        chk({tag, " R11 fail_count"}, fail_count, exp_fail);
        chk({tag, " R10 corrected_total"}, corrected_total, exp_corr);
    endtask

    task automatic t_reset();
        chk("R1 res_valid", res_valid, 0);
        chk("R1 page_ok", page_ok, 0);
        chk("R1 fail_count", fail_count, 0);
        chk("R1 corrected_total", corrected_total, 0);
    endtask

    task automatic t_decoded_ok();   // R3: decoded page never reclassified
        set_blank(); zap(0, 20); zap(17, 31);
        rc[0] = 1; rc[1] = 3; rc[2] = 2; rc[3] = 0;
        run_page("R3", 1'b0, 9, 1'b0);
    endtask

    task automatic t_blank();        // R4: clean blank page
        set_blank();
        run_page("R4", 1'b1, 77, 1'b0);
    endtask

    task automatic t_tolerance();    // R7: exactly THRESH in a region and spare, total above THRESH
        set_blank(); zap(2, 3); zap(RW * 3 - 1, 4); zap(DW + 1, 2); zap(NW - 1, 2);
        run_page("R7", 1'b1, 0, 1'b0);
    endtask

    task automatic t_stall();        // R12: bubbles inside the page
        set_blank(); zap(1, 2); zap(RW + 4, 4); zap(DW + 2, 1);
        run_page("R12", 1'b1, 0, 1'b1);
    endtask

    task automatic t_region_over();  // R5: one region above THRESH
        set_blank(); zap(RW + 3, 3); zap(2 * RW - 1, 2);
        run_page("R5", 1'b1, 0, 1'b0);
    endtask

    task automatic t_spare_over();   // R6: spare above THRESH, data clean
        set_blank(); zap(DW, 3); zap(NW - 1, 2);
        run_page("R6", 1'b1, 0, 1'b0);
    endtask

    task automatic t_restart();      // R8: restart mid-page drops earlier words
        @(negedge clk); page_start = 1'b1;
        @(negedge clk); page_start = 1'b0;
        for (int i = 0; i < RW + 3; i++) begin
            in_word = 32'h0; in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        set_blank();
        run_page("R8", 1'b1, 0, 1'b0);
    endtask

    task automatic t_idle_ignore();  // R9: idle words produce nothing
        int seen;
        seen = 0;
        for (int i = 0; i < NW + 2; i++) begin
            in_word = 32'h0; in_valid = 1'b1;
            @(negedge clk);
            if (res_valid) seen++;
        end
        in_valid = 1'b0;
        chk("R9 no result from idle words", seen, 0);
        set_blank(); zap(5, 1);
        run_page("R9", 1'b1, 0, 1'b0);
    endtask

    task automatic t_fail_saturate(); // R11
        set_blank(); zap(0, 10);
        for (int k = 0; k < 9; k++) run_page("R11", 1'b1, 0, 1'b0);
        chk("R11 saturated fail_count", fail_count, FAIL_MAX);
    endtask

    task automatic t_stat_saturate(); // R10
        set_blank();
        for (int k = 0; k < 5; k++) run_page("R10", 1'b0, 255, 1'b0);
        chk("R10 saturated corrected_total", corrected_total, STAT_MAX);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decoded_ok();
        t_blank();
        t_tolerance();
        t_stall();
        t_region_over();
        t_spare_over();
        t_restart();
        t_idle_ignore();
        t_fail_saturate();
        t_stat_saturate();
        report();
        $finish;
    end
endmodule